// File: doc/BRIEF.md
# Two-Channel Target-Compare Pulse Counter

This block holds two independent up counters, each advanced by one count in every clock cycle in which its pulse input is high. Each channel owns two compare registers. A compare register drives a match output of its own: when the counter reaches the loaded value, the output moves to a level picked per target. New compare values wait in staging inputs. They become active only when the channel's load bit rises.

One 16-bit control word configures the block, with one byte per channel. Channel 0 uses bits 7..0 and channel 1 uses bits 15..8. Inside a channel byte, the field positions are:

- bits 0 and 1: match polarity of target 0 and target 1;
- bit 2: software clear;
- bit 3: gate on the external reset;
- bit 4: match-output disable;
- bit 5: target load;
- bit 7 of the whole word (channel 0 byte only): count format, where 1 selects binary and 0 selects BCD.

Each channel also has an external reset input and a reset-enable input. When the gate is set, a remembered enable window decides whether an external reset is accepted. Targets are indexed channel*2+target on `match_out` and on the `stage_tgt` slices.

Top module: `dual_match_counter`

## Requirements
- R1: With the software clear and the external reset inactive, a channel's count rises by exactly one on each clock edge where its pulse input is high, and otherwise holds. In binary format (control bit 7 = 1) it wraps from 2^CW-1 to 0.
- R2: In BCD format (control bit 7 = 0), each 4-bit digit of the count runs 0 to 9 and carries into the next digit. An all-nines count wraps to zero.
- R3: The software clear bit (bit 2 for channel 0, bit 10 for channel 1) zeroes the count at the next edge. It overrides a pulse in the same cycle.
- R4: With the gate bit clear (bit 3 / bit 11 = 0), a rising edge on the external reset input zeroes the count at that edge.
- R5: With the gate bit set, an external reset rising edge is accepted only in two cases: while the reset-enable input is high, or as the first edge after the enable has been high and has since fallen. All other edges are ignored. A reset input that stays high is one edge.
- R6: Targets and their polarity bits (bits 0,1 for channel 0; bits 8,9 for channel 1) are copied from the staging inputs only on a 0-to-1 change of the load bit (bit 5 / bit 13). Holding the load bit high loads nothing. On a load, the output is set to its starting level: off for polarity 0, on for polarity 1.
- R7: Once a target is loaded, whenever the channel's updated count equals it, the output goes to the match level: on for polarity 0, off for polarity 1. A polarity bit changed without a reload has no effect.
- R8: The disable bit (bit 4 / bit 12) forces both of the channel's match outputs to 0. The outputs' states are kept, and they reappear when the bit clears.
- R9: Pulses, clears and loads on one channel leave the other channel's count and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Control word, one byte per channel |
| stage_tgt | input | 4*CW | Staged target values, slice (ch*2+t)*CW |
| pulse_in | input | 2 | Count pulse per channel |
| ext_rst_in | input | 2 | External reset per channel (edge sensitive) |
| ext_rst_en | input | 2 | External reset enable per channel |
| count_out | output | 2*CW | Elapsed counts, channel 0 in the low slice |
| match_out | output | 4 | Match outputs, index ch*2+t |

## Verification
The bench builds the block with DIGITS = 2, which makes an 8-bit count. This puts the binary wrap at 255 and the BCD wrap at 99 within a few hundred cycles, so both rollovers and the decimal carry from 09 to 10 are driven directly. The small width also keeps target matches a handful of pulses away from a cleared count. This leaves room to walk the full external-reset window sequence and the held-load case on channel 0 while channel 1 counts on its own.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;

    localparam int NUM_CH     = 2;
    localparam int TGT_PER_CH = 2;
    localparam int CTRL_BITS  = 8;

    // one channel byte of the control word, MSB first
    typedef struct packed {
        logic       spare_hi;   // bit 7 (format bit on channel 0, handled at top)
        logic       spare_lo;   // bit 6
        logic       load;       // bit 5
        logic       out_off;    // bit 4
        logic       ext_gate;   // bit 3
        logic       soft_clr;   // bit 2
        logic [1:0] polarity;   // bits 1..0, one per target
    } ch_ctrl_t;

    typedef enum logic {
        FMT_BCD = 1'b0,
        FMT_BIN = 1'b1
    } cnt_fmt_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_INC,
        ACT_SOFT_CLR,
        ACT_EXT_CLR
    } cnt_act_e;

    // one decimal digit step: returns {carry_out, digit}
    function automatic logic [4:0] digit_inc(input logic [3:0] d, input logic cin);
        if (!cin)
            return {1'b0, d};
        else if (d >= 4'd9)
            return {1'b1, 4'd0};
        else
            return {1'b0, d + 4'd1};
    endfunction

endpackage

// File: rtl/dmc_ext_gate.sv
`timescale 1ns/1ps
module dmc_ext_gate (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_i,
    input  logic ext_en_i,
    input  logic gate_i,
    output logic ext_hit_o
);
    logic ext_q;
    logic armed_q;
    logic ext_edge;

    assign ext_edge  = ext_rst_i & ~ext_q;
    assign ext_hit_o = ext_edge & (~gate_i | ext_en_i | armed_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ext_q <= ext_rst_i;
            if (ext_en_i)
                armed_q <= 1'b1;
            else if (ext_edge && gate_i && armed_q)
                armed_q <= 1'b0;
        end
    end

    AST_EN_ARMS: assert property (@(posedge clk) disable iff (rst)
        ext_en_i |=> armed_q);                                     // R5
    AST_WINDOW_SPENT: assert property (@(posedge clk) disable iff (rst)
        (ext_hit_o && gate_i && !ext_en_i) |=> !armed_q);          // R5
    AST_HELD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        (ext_rst_i && $past(ext_rst_i)) |-> !ext_hit_o);           // R5

endmodule

// File: rtl/dmc_count_core.sv
`timescale 1ns/1ps
module dmc_count_core
    import dmc_pkg::*;
#(
    parameter int DIGITS = 6,
    localparam int CW    = 4 * DIGITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse_i,
    input  logic          soft_clr_i,
    input  logic          ext_hit_i,
    input  cnt_fmt_e      fmt_i,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] count_nxt_o
);
    logic [CW-1:0] count_q;
    logic [CW-1:0] bin_inc;
    logic [CW-1:0] bcd_inc;
    logic [CW-1:0] inc_val;
    cnt_act_e      act;

    function automatic logic bcd_ok(input logic [CW-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++)
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    always_comb begin
        logic       carry;
        logic [4:0] dr;
        bin_inc = count_q + 1'b1;
        carry   = 1'b1;
        bcd_inc = '0;
        for (int i = 0; i < DIGITS; i++) begin
            dr               = digit_inc(count_q[4*i +: 4], carry);
            bcd_inc[4*i +: 4] = dr[3:0];
            carry            = dr[4];
        end
        inc_val = (fmt_i == FMT_BIN) ? bin_inc : bcd_inc;
    end

    always_comb begin
        if (soft_clr_i)
            act = ACT_SOFT_CLR;
        else if (ext_hit_i)
            act = ACT_EXT_CLR;
        else if (pulse_i)
            act = ACT_INC;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        case (act)
            ACT_SOFT_CLR,
            ACT_EXT_CLR:  count_nxt_o = '0;
            ACT_INC:      count_nxt_o = inc_val;
            default:      count_nxt_o = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else
            count_q <= count_nxt_o;
    end

    assign count_o = count_q;

    AST_SOFT_CLR: assert property (@(posedge clk) disable iff (rst)
        soft_clr_i |=> (count_q == '0));                           // R3
    AST_EXT_CLR: assert property (@(posedge clk) disable iff (rst)
        ext_hit_i |=> (count_q == '0));                            // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pulse_i && !soft_clr_i && !ext_hit_i) |=> $stable(count_q)); // R1
    AST_BCD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (fmt_i == FMT_BCD && bcd_ok(count_q)) |=> bcd_ok(count_q));  // R2

endmodule

// File: rtl/dmc_target.sv
`timescale 1ns/1ps
module dmc_target #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_bit_i,
    input  logic          polarity_i,
    input  logic [CW-1:0] stage_i,
    input  logic [CW-1:0] count_nxt_i,
    output logic          state_o
);
    logic [CW-1:0] tgt_q;
    logic          pol_q;
    logic          valid_q;
    logic          out_q;
    logic          ld_prev_q;
    logic          load_edge;
    logic          hit;

    assign load_edge = ld_bit_i & ~ld_prev_q;
    assign hit       = valid_q & (count_nxt_i == tgt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q     <= '0;
            pol_q     <= 1'b0;
            valid_q   <= 1'b0;
            out_q     <= 1'b0;
            ld_prev_q <= 1'b0;
        end else begin
            ld_prev_q <= ld_bit_i;
            if (load_edge) begin
                tgt_q   <= stage_i;
                pol_q   <= polarity_i;
                valid_q <= 1'b1;
                out_q   <= polarity_i;      // start level: off for 0, on for 1
            end else if (hit) begin
                out_q   <= ~pol_q;          // match level
            end
        end
    end

    assign state_o = out_q;

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        load_edge |=> (tgt_q == $past(stage_i) && out_q == $past(polarity_i))); // R6
    AST_HELD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ld_bit_i && ld_prev_q) |=> ($stable(tgt_q) && $stable(pol_q)));      // R6
    AST_MATCH_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !load_edge && count_nxt_i == tgt_q) |=> (out_q == ~pol_q)); // R7

endmodule

// File: rtl/dmc_channel.sv
`timescale 1ns/1ps
module dmc_channel
    import dmc_pkg::*;
#(
    parameter int DIGITS = 6,
    localparam int CW    = 4 * DIGITS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  ch_ctrl_t                 ctrl_i,
    input  cnt_fmt_e                 fmt_i,
    input  logic [TGT_PER_CH*CW-1:0] stage_i,
    input  logic                     pulse_i,
    input  logic                     ext_rst_i,
    input  logic                     ext_en_i,
    output logic [CW-1:0]            count_o,
    output logic [TGT_PER_CH-1:0]    match_o
);
    logic                  ext_hit;
    logic [CW-1:0]         count_nxt;
    logic [TGT_PER_CH-1:0] state;
    logic                  unused_spare;

    assign unused_spare = ctrl_i.spare_hi ^ ctrl_i.spare_lo;

    dmc_ext_gate i_gate (
        .clk       (clk),
        .rst       (rst),
        .ext_rst_i (ext_rst_i),
        .ext_en_i  (ext_en_i),
        .gate_i    (ctrl_i.ext_gate),
        .ext_hit_o (ext_hit)
    );

    dmc_count_core #(.DIGITS(DIGITS)) i_core (
        .clk         (clk),
        .rst         (rst),
        .pulse_i     (pulse_i),
        .soft_clr_i  (ctrl_i.soft_clr),
        .ext_hit_i   (ext_hit),
        .fmt_i       (fmt_i),
        .count_o     (count_o),
        .count_nxt_o (count_nxt)
    );

    for (genvar t = 0; t < TGT_PER_CH; t++) begin : g_tgt
        dmc_target #(.CW(CW)) i_tgt (
            .clk         (clk),
            .rst         (rst),
            .ld_bit_i    (ctrl_i.load),
            .polarity_i  (ctrl_i.polarity[t]),
            .stage_i     (stage_i[t*CW +: CW]),
            .count_nxt_i (count_nxt),
            .state_o     (state[t])
        );
    end

    assign match_o = ctrl_i.out_off ? '0 : state;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.out_off |-> (match_o == '0));                        // R8

endmodule

// File: rtl/dual_match_counter.sv
`timescale 1ns/1ps
module dual_match_counter
    import dmc_pkg::*;
#(
    parameter int DIGITS = 6,
    localparam int CW    = 4 * DIGITS,
    localparam int NOUT  = NUM_CH * TGT_PER_CH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [15:0]          ctrl_word,
    input  logic [NOUT*CW-1:0]   stage_tgt,
    input  logic [NUM_CH-1:0]    pulse_in,
    input  logic [NUM_CH-1:0]    ext_rst_in,
    input  logic [NUM_CH-1:0]    ext_rst_en,
    output logic [NUM_CH*CW-1:0] count_out,
    output logic [NOUT-1:0]      match_out
);
    cnt_fmt_e fmt;
    assign fmt = cnt_fmt_e'(ctrl_word[7]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_ctrl_t cc;
        assign cc = ch_ctrl_t'(ctrl_word[c*CTRL_BITS +: CTRL_BITS]);

        dmc_channel #(.DIGITS(DIGITS)) i_ch (
            .clk       (clk),
            .rst       (rst),
            .ctrl_i    (cc),
            .fmt_i     (fmt),
            .stage_i   (stage_tgt[c*TGT_PER_CH*CW +: TGT_PER_CH*CW]),
            .pulse_i   (pulse_in[c]),
            .ext_rst_i (ext_rst_in[c]),
            .ext_en_i  (ext_rst_en[c]),
            .count_o   (count_out[c*CW +: CW]),
            .match_o   (match_out[c*TGT_PER_CH +: TGT_PER_CH])
        );
    end

endmodule

// File: tb/test_dual_match_counter.sv
`timescale 1ns/1ps
module test_dual_match_counter;
    localparam int DIGITS = 2;
    localparam int CW     = 4 * DIGITS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       ctrl_word = 16'h0080;
    logic [4*CW-1:0]   stage_tgt = '0;
    logic [1:0]        pulse_in = '0;
    logic [1:0]        ext_rst_in = '0;
    logic [1:0]        ext_rst_en = '0;
    logic [2*CW-1:0]   count_out;
    logic [3:0]        match_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dual_match_counter #(.DIGITS(DIGITS)) i_dual_match_counter (
        .clk        (clk),
        .rst        (rst),
        .ctrl_word  (ctrl_word),
        .stage_tgt  (stage_tgt),
        .pulse_in   (pulse_in),
        .ext_rst_in (ext_rst_in),
        .ext_rst_en (ext_rst_en),
        .count_out  (count_out),
        .match_out  (match_out)
    );

    typedef struct packed {
        logic [15:0]   ctrl;
        logic          p;
        logic          e;
        logic          en;
        logic [CW-1:0] exp_cnt;
        logic [7:0]    req;
    } vec_t;

    // channel 0 sequence, channel 1 idle; expected count after each edge
    localparam vec_t TBL [16] = '{
        '{16'h0080, 1'b1, 1'b0, 1'b0, 8'd1, 8'd1},  // R1 count
        '{16'h0080, 1'b1, 1'b0, 1'b0, 8'd2, 8'd1},  // R1 count
        '{16'h0080, 1'b0, 1'b0, 1'b0, 8'd2, 8'd1},  // R1 hold
        '{16'h0084, 1'b1, 1'b0, 1'b0, 8'd0, 8'd3},  // R3 clear beats pulse
        '{16'h0080, 1'b1, 1'b0, 1'b0, 8'd1, 8'd1},
        '{16'h0080, 1'b1, 1'b0, 1'b0, 8'd2, 8'd1},
        '{16'h0080, 1'b0, 1'b1, 1'b0, 8'd0, 8'd4},  // R4 ungated edge
        '{16'h0080, 1'b1, 1'b0, 1'b0, 8'd1, 8'd1},
        '{16'h0088, 1'b1, 1'b1, 1'b0, 8'd2, 8'd5},  // R5 gated, never enabled
        '{16'h0088, 1'b0, 1'b0, 1'b1, 8'd2, 8'd5},  // R5 enable opens window
        '{16'h0088, 1'b1, 1'b1, 1'b1, 8'd0, 8'd5},  // R5 inside window
        '{16'h0088, 1'b1, 1'b0, 1'b0, 8'd1, 8'd5},
        '{16'h0088, 1'b1, 1'b1, 1'b0, 8'd0, 8'd5},  // R5 first after close
        '{16'h0088, 1'b1, 1'b0, 1'b0, 8'd1, 8'd5},
        '{16'h0088, 1'b1, 1'b1, 1'b0, 8'd2, 8'd5},  // R5 window spent
        '{16'h0088, 1'b0, 1'b1, 1'b0, 8'd2, 8'd5}   // R5 held high, no edge
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] c, input logic [1:0] p,
                        input logic [1:0] e, input logic [1:0] en);
        ctrl_word  = c;
        pulse_in   = p;
        ext_rst_in = e;
        ext_rst_en = en;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(16'h0080, 2'b00, 2'b00, 2'b00);
        rst = 1'b0;
        step(16'h0080, 2'b00, 2'b00, 2'b00);
        check("R1 reset count", count_out, '0);
        check("R6 reset outputs", match_out, 4'b0000);

        // vector table on channel 0
        for (int i = 0; i < 16; i++) begin
            step(TBL[i].ctrl, {1'b0, TBL[i].p}, {1'b0, TBL[i].e}, {1'b0, TBL[i].en});
            check($sformatf("R%0d vec%0d", TBL[i].req, i), count_out[CW-1:0], TBL[i].exp_cnt);
        end
        check("R9 ch1 untouched by table", count_out[2*CW-1:CW], '0);

        // R6 / R7: load targets t0=5 (polarity 0), t1=3 (polarity 1)
        stage_tgt[0*CW +: CW] = 8'd5;
        stage_tgt[1*CW +: CW] = 8'd3;
        step(16'h0086, 2'b00, 2'b00, 2'b00);
        step(16'h00A2, 2'b00, 2'b00, 2'b00);
        check("R6 start levels on load", match_out[1:0], 2'b10);
        step(16'h00A2, 2'b01, 2'b00, 2'b00);
        step(16'h00A2, 2'b01, 2'b00, 2'b00);
        check("R7 before match", match_out[1:0], 2'b10);
        step(16'h00A2, 2'b01, 2'b00, 2'b00);
        check("R7 t1 turns off at 3", match_out[1:0], 2'b00);
        step(16'h00A2, 2'b01, 2'b00, 2'b00);
        step(16'h00A2, 2'b01, 2'b00, 2'b00);
        check("R7 t0 turns on at 5", match_out[1:0], 2'b01);

        // R8: disable hides, enable restores
        step(16'h00B2, 2'b00, 2'b00, 2'b00);
        check("R8 outputs forced low", match_out[1:0], 2'b00);
        step(16'h00A2, 2'b00, 2'b00, 2'b00);
        check("R8 state restored", match_out[1:0], 2'b01);

        // R6 held load bit: new stage and polarity ignored
        stage_tgt[0*CW +: CW] = 8'd2;
        step(16'h00A7, 2'b00, 2'b00, 2'b00);
        step(16'h00A3, 2'b01, 2'b00, 2'b00);
        step(16'h00A3, 2'b01, 2'b00, 2'b00);
        check("R6 held bit loads nothing", match_out[0], 1'b1);
        step(16'h0083, 2'b00, 2'b00, 2'b00);
        step(16'h00A3, 2'b00, 2'b00, 2'b00);
        check("R6 reload start level", match_out[0], 1'b1);
        step(16'h00A3, 2'b00, 2'b00, 2'b00);
        check("R7 new polarity match", match_out[0], 1'b0);

        // R2: BCD counting on channel 0
        step(16'h0004, 2'b00, 2'b00, 2'b00);
        for (int i = 0; i < 9; i++) step(16'h0000, 2'b01, 2'b00, 2'b00);
        check("R2 digit 9", count_out[CW-1:0], 8'h09);
        step(16'h0000, 2'b01, 2'b00, 2'b00);
        check("R2 carry to 10", count_out[CW-1:0], 8'h10);
        for (int i = 0; i < 89; i++) step(16'h0000, 2'b01, 2'b00, 2'b00);
        check("R2 reach 99", count_out[CW-1:0], 8'h99);
        step(16'h0000, 2'b01, 2'b00, 2'b00);
        check("R2 wrap to 00", count_out[CW-1:0], 8'h00);

        // R1 binary wrap on channel 1, R9 independence
        step(16'h0480, 2'b00, 2'b00, 2'b00);
        for (int i = 0; i < 255; i++) step(16'h0080, 2'b10, 2'b00, 2'b00);
        check("R1 ch1 at 255", count_out[2*CW-1:CW], 8'hFF);
        check("R9 ch0 unchanged", count_out[CW-1:0], 8'h00);
        step(16'h0080, 2'b10, 2'b00, 2'b00);
        check("R1 binary wrap", count_out[2*CW-1:CW], 8'h00);
        check("R9 ch1 outputs quiet", match_out[3:2], 2'b00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule